// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

A memory-mapped general-purpose I/O block for a pin count that is a multiple of 32. Each register kind occupies its own bank of consecutive 32-bit words, with one word per 32 pins, or one word per 16 pins for the alternate-function selector. Software sets the per-pin direction. It changes outputs through separate write-one set and clear registers, so no read-modify-write is needed to move a single pin. It reads back the synchronized pin level.

Each pin can record rising and falling edges into a sticky status bit, which software clears by writing a one to it. All status bits are ORed into one registered interrupt line. A 2-bit alternate-function code per pin is exported for the pad mux.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction, output, edge-enable, edge-status and alternate-function bit is 0, and `irq_o` is 0.
- R2: With N = NUM_PINS/32, register kind t (0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status, 7 alternate function) has its word r at byte address t*N*4 + r*4. Pin p uses word p/32 and bit p%32. The alternate-function bank spans 2N words. Reads of set, clear, any address at or above 9*N*4, and any address whose two low bits are not 00 return 0, and writes to those addresses change nothing.
- R3: Writing a word of the set bank drives `pin_o` high for each bit written as 1. Bits written as 0 leave their outputs unchanged.
- R4: Writing a word of the clear bank drives `pin_o` low for each bit written as 1. Bits written as 0 leave their outputs unchanged.
- R5: The direction bank is read/write. A 1 makes the pin an output and is presented on `pin_oe_o`.
- R6: The level bank reads `pin_i` through a two-flop synchronizer: a change on a pin appears in the read data after the second rising clock edge.
- R7: With its rising enable set, a pin whose synchronized level goes 0 to 1 sets its status bit on the next clock edge. A status bit never becomes set for a pin with both enables clear.
- R8: With its falling enable set, a 1 to 0 transition sets the status bit. With both enables set, either edge sets it.
- R9: Status bits are write-one-to-clear. Writing 0 has no effect. A new edge in the same cycle as a clear of that bit leaves the bit set.
- R10: `irq_o` is the OR of all status bits, delayed by one clock.
- R11: The alternate-function code of pin p is 2 bits at word p/16 of its bank, bits (p%16)*2+1:(p%16)*2. It is read/write and is exported on `altfn_o[2p+1:2p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_i | input | NUM_PINS | Pin inputs |
| pin_o | output | NUM_PINS | Pin output values |
| pin_oe_o | output | NUM_PINS | Pin output enables |
| altfn_o | output | 2*NUM_PINS | Alternate-function codes, 2 bits per pin |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The checker confirms on every cycle the following:
- the interrupt follows the OR of the status bits one cycle late;
- status bits only rise on pins with an enable set;
- status bits only fall on a write to the status bank;
- outputs, output enables and function codes stay unchanged unless their own bank is written.

Only the bench scenarios can show the rest:
- exact address decoding and read values;
- the two-edge synchronizer latency;
- the priority of a new edge over a same-cycle clear;
- the masking of zero bits in set and clear writes.

These scenarios run as directed cases and as a long random mix of bus traffic and pin toggles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_BITS   = 32;
  localparam int AF_BITS     = 2;
  localparam int AF_PER_WORD = WORD_BITS / AF_BITS;

  // bank order is software-visible
  typedef enum logic [3:0] {
    RK_LEVEL = 4'd0,
    RK_DIR   = 4'd1,
    RK_SET   = 4'd2,
    RK_CLR   = 4'd3,
    RK_RISE  = 4'd4,
    RK_FALL  = 4'd5,
    RK_STAT  = 4'd6,
    RK_ALT   = 4'd7
  } reg_kind_e;

  function automatic int bank_base(reg_kind_e k, int words);
    return int'(k) * words;
  endfunction

  function automatic int addr_width(int pins);
    return $clog2((pins / WORD_BITS) * 9 * 4);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] sts_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic prev_q, sts_q, hit;

    assign hit = (rise_en_i[p] &  lvl_i[p] & ~prev_q) |
                 (fall_en_i[p] & ~lvl_i[p] &  prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        sts_q  <= 1'b0;
      end else begin
        prev_q <= lvl_i[p];
        sts_q  <= (sts_q & ~clr_i[p]) | hit;  // new edge beats clear
      end
    end

    assign sts_o[p] = sts_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   lvl_i,
  input  logic [NUM_PINS-1:0]   sts_i,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   out_o,
  output logic [NUM_PINS-1:0]   rise_en_o,
  output logic [NUM_PINS-1:0]   fall_en_o,
  output logic [NUM_PINS-1:0]   clr_o,
  output logic [2*NUM_PINS-1:0] af_o
);
  localparam int NW    = NUM_PINS / WORD_BITS;
  localparam int AFW   = NUM_PINS / AF_PER_WORD;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_ok, aligned;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = we_i & aligned;

  for (genvar r = 0; r < NW; r++) begin : g_word
    localparam int A_DIR  = bank_base(RK_DIR,  NW) + r;
    localparam int A_SET  = bank_base(RK_SET,  NW) + r;
    localparam int A_CLR  = bank_base(RK_CLR,  NW) + r;
    localparam int A_RISE = bank_base(RK_RISE, NW) + r;
    localparam int A_FALL = bank_base(RK_FALL, NW) + r;
    localparam int A_STAT = bank_base(RK_STAT, NW) + r;

    logic        hit_dir, hit_set, hit_clr, hit_rise, hit_fall, hit_stat;
    logic [31:0] dir_q, out_q, rise_q, fall_q;

    assign hit_dir  = wr_ok && (idx == IDX_W'(A_DIR));
    assign hit_set  = wr_ok && (idx == IDX_W'(A_SET));
    assign hit_clr  = wr_ok && (idx == IDX_W'(A_CLR));
    assign hit_rise = wr_ok && (idx == IDX_W'(A_RISE));
    assign hit_fall = wr_ok && (idx == IDX_W'(A_FALL));
    assign hit_stat = wr_ok && (idx == IDX_W'(A_STAT));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q  <= '0;
        out_q  <= '0;
        rise_q <= '0;
        fall_q <= '0;
      end else begin
        if (hit_dir)  dir_q  <= wdata_i;
        if (hit_set)  out_q  <= out_q | wdata_i;
        if (hit_clr)  out_q  <= out_q & ~wdata_i;
        if (hit_rise) rise_q <= wdata_i;
        if (hit_fall) fall_q <= wdata_i;
      end
    end

    assign dir_o    [r*WORD_BITS +: WORD_BITS] = dir_q;
    assign out_o    [r*WORD_BITS +: WORD_BITS] = out_q;
    assign rise_en_o[r*WORD_BITS +: WORD_BITS] = rise_q;
    assign fall_en_o[r*WORD_BITS +: WORD_BITS] = fall_q;
    assign clr_o    [r*WORD_BITS +: WORD_BITS] = hit_stat ? wdata_i : '0;
  end

  for (genvar k = 0; k < AFW; k++) begin : g_af
    localparam int A_ALT = bank_base(RK_ALT, NW) + k;
    logic        hit_alt;
    logic [31:0] af_q;

    assign hit_alt = wr_ok && (idx == IDX_W'(A_ALT));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      af_q <= '0;
      else if (hit_alt) af_q <= wdata_i;
    end

    assign af_o[k*WORD_BITS +: WORD_BITS] = af_q;
  end

  // set/clear banks read as zero
  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      for (int r = 0; r < NW; r++) begin
        if (idx == IDX_W'(bank_base(RK_LEVEL, NW) + r)) rdata_o = lvl_i    [r*WORD_BITS +: WORD_BITS];
        if (idx == IDX_W'(bank_base(RK_DIR,   NW) + r)) rdata_o = dir_o    [r*WORD_BITS +: WORD_BITS];
        if (idx == IDX_W'(bank_base(RK_RISE,  NW) + r)) rdata_o = rise_en_o[r*WORD_BITS +: WORD_BITS];
        if (idx == IDX_W'(bank_base(RK_FALL,  NW) + r)) rdata_o = fall_en_o[r*WORD_BITS +: WORD_BITS];
        if (idx == IDX_W'(bank_base(RK_STAT,  NW) + r)) rdata_o = sts_i    [r*WORD_BITS +: WORD_BITS];
      end
      for (int k = 0; k < AFW; k++) begin
        if (idx == IDX_W'(bank_base(RK_ALT, NW) + k)) rdata_o = af_o[k*WORD_BITS +: WORD_BITS];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_PINS = 64,
  localparam int ADDR_W   = addr_width(NUM_PINS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [2*NUM_PINS-1:0] altfn_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] lvl_w, sts_w, ren_w, fen_w, clr_w;
  logic                irq_q;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_w)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .lvl_i    (lvl_w),
    .sts_i    (sts_w),
    .dir_o    (pin_oe_o),
    .out_o    (pin_o),
    .rise_en_o(ren_w),
    .fall_en_o(fen_w),
    .clr_o    (clr_w),
    .af_o     (altfn_o)
  );

  gpio_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl_w),
    .rise_en_i(ren_w),
    .fall_en_i(fen_w),
    .clr_i    (clr_w),
    .sts_o    (sts_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |sts_w;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_PINS = 64,
  localparam int ADDR_W   = addr_width(NUM_PINS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  we_i,
  input logic [NUM_PINS-1:0]   pin_o,
  input logic [NUM_PINS-1:0]   pin_oe_o,
  input logic [2*NUM_PINS-1:0] altfn_o,
  input logic                  irq_o,
  input logic [NUM_PINS-1:0]   sts_i,
  input logic [NUM_PINS-1:0]   ren_i,
  input logic [NUM_PINS-1:0]   fen_i
);
  localparam int NB = (NUM_PINS / WORD_BITS) * 4;  // bytes per bank
  int unsigned a;
  logic wr_dir, wr_out, wr_stat, wr_alt;

  assign a       = int'(addr_i);
  assign wr_dir  = we_i && a >= 1*NB && a < 2*NB;
  assign wr_out  = we_i && a >= 2*NB && a < 4*NB;
  assign wr_stat = we_i && a >= 6*NB && a < 7*NB;
  assign wr_alt  = we_i && a >= 7*NB && a < 9*NB;

  p_irq_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sts_i) |=> irq_o);
  p_irq_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|sts_i) |=> !irq_o);
  p_sts_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & ~$past(sts_i) & ~$past(ren_i | fen_i)) == '0));
  p_sts_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((sts_i & $past(sts_i)) == $past(sts_i)));
  p_oe_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(pin_oe_o));
  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_out |=> $stable(pin_o));
  p_af_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_alt |=> $stable(altfn_o));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .altfn_o (altfn_o),
  .irq_o   (irq_o),
  .sts_i   (sts_w),
  .ren_i   (ren_w),
  .fen_i   (fen_w)
);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int P   = 64;
  localparam int NW  = P / 32;
  localparam int AFW = P / 16;
  localparam int AW  = gpio_bank_pkg::addr_width(P);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0, rdata;
  logic [P-1:0]  pins = '0, pin_o, pin_oe;
  logic [2*P-1:0] altfn;
  logic          irq;

  always #10 clk = ~clk;  // 50 MHz

  gpio_bank_ctrl #(.NUM_PINS(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .altfn_o(altfn), .irq_o(irq)
  );

  // reference model
  logic [P-1:0]   m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_st;
  logic [2*P-1:0] m_af;
  logic           m_irq;

  always @(posedge clk or negedge rst_n) begin : mdl
    int idx, t, r;
    logic [P-1:0] edg, clr;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_dir <= '0; m_out <= '0;
      m_ren <= '0; m_fen <= '0; m_st <= '0; m_af <= '0; m_irq <= 1'b0;
    end else begin
      edg = (m_s2 & ~m_prev & m_ren) | (~m_s2 & m_prev & m_fen);
      clr = '0;
      idx = int'(addr) >> 2;
      t = idx / NW;
      r = idx % NW;
      if (we && addr[1:0] == 2'b00 && idx < 9*NW) begin
        case (t)
          1: m_dir[r*32 +: 32] <= wdata;
          2: m_out[r*32 +: 32] <= m_out[r*32 +: 32] | wdata;
          3: m_out[r*32 +: 32] <= m_out[r*32 +: 32] & ~wdata;
          4: m_ren[r*32 +: 32] <= wdata;
          5: m_fen[r*32 +: 32] <= wdata;
          6: clr[r*32 +: 32] = wdata;
          7, 8: m_af[(idx-7*NW)*32 +: 32] <= wdata;
          default: ;
        endcase
      end
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      m_st <= (m_st & ~clr) | edg;
      m_irq <= |m_st;
    end
  end

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    int idx = int'(a) >> 2;
    int t = idx / NW;
    int r = idx % NW;
    if (a[1:0] != 2'b00 || idx >= 9*NW) return '0;
    case (t)
      0: return m_s2[r*32 +: 32];
      1: return m_dir[r*32 +: 32];
      4: return m_ren[r*32 +: 32];
      5: return m_fen[r*32 +: 32];
      6: return m_st[r*32 +: 32];
      7, 8: return m_af[(idx-7*NW)*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] a_of(int t, int r);
    return AW'(t*NW*4 + r*4);
  endfunction

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [2*P-1:0] got, input logic [2*P-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, {{(2*P-32){1'b0}}, rdata}, {{(2*P-32){1'b0}}, exp});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cmp_outputs();
    chk("R3/R4 pin_o", {{P{1'b0}}, pin_o}, {{P{1'b0}}, m_out});
    chk("R5 pin_oe", {{P{1'b0}}, pin_oe}, {{P{1'b0}}, m_dir});
    chk("R11 altfn", altfn, m_af);
    chk("R10 irq", {{(2*P-1){1'b0}}, irq}, {{(2*P-1){1'b0}}, m_irq});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pin_o", {{P{1'b0}}, pin_o}, '0);
    chk("R1 pin_oe", {{P{1'b0}}, pin_oe}, '0);
    chk("R1 altfn", altfn, '0);
    chk("R1 irq", {{(2*P-1){1'b0}}, irq}, '0);
    for (int i = 0; i < 9*NW; i++) rd_chk("R1 regs", AW'(i*4), 32'h0);

    // R3 set, R2 set reads zero
    wr(a_of(2, 1), 32'h8000_0001);
    chk("R3 set", {{P{1'b0}}, pin_o}, {{P{1'b0}}, 64'h8000_0001_0000_0000});
    wr(a_of(2, 1), 32'h0);
    chk("R3 zero bits", {{P{1'b0}}, pin_o}, {{P{1'b0}}, 64'h8000_0001_0000_0000});
    rd_chk("R2 set reads 0", a_of(2, 1), 32'h0);
    // R4 clear
    wr(a_of(3, 1), 32'h0000_0001);
    chk("R4 clear", {{P{1'b0}}, pin_o}, {{P{1'b0}}, 64'h8000_0000_0000_0000});
    rd_chk("R2 clr reads 0", a_of(3, 1), 32'h0);
    // R5 direction
    wr(a_of(1, 0), 32'h0000_00F0);
    chk("R5 oe", {{P{1'b0}}, pin_oe}, {{P{1'b0}}, 64'h0000_0000_0000_00F0});
    rd_chk("R5 dir readback", a_of(1, 0), 32'h0000_00F0);

    // R6 synchronizer latency
    pins[5] = 1'b1;
    rd_chk("R6 level t0", a_of(0, 0), 32'h0);
    @(negedge clk); rd_chk("R6 level t1", a_of(0, 0), 32'h0);
    @(negedge clk); rd_chk("R6 level t2", a_of(0, 0), 32'h20);

    // R7 rising edge on pin 3, R10 irq delay
    wr(a_of(4, 0), 32'h8);
    pins[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R7 not yet", a_of(6, 0), 32'h0);
    @(negedge clk);
    rd_chk("R7 rise", a_of(6, 0), 32'h8);
    chk("R10 irq lag", {{(2*P-1){1'b0}}, irq}, '0);
    @(negedge clk);
    chk("R10 irq set", {{(2*P-1){1'b0}}, irq}, 1);

    // R8 falling edge on pin 34
    wr(a_of(5, 1), 32'h4);
    pins[34] = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R8 rise ignored", a_of(6, 1), 32'h0);
    pins[34] = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R8 fall", a_of(6, 1), 32'h4);

    // R9 write-one-to-clear
    wr(a_of(6, 1), 32'h0);
    rd_chk("R9 zero write", a_of(6, 1), 32'h4);
    wr(a_of(6, 0), 32'hFFFF_FFFF);
    rd_chk("R9 clear all w0", a_of(6, 0), 32'h0);
    rd_chk("R9 other word", a_of(6, 1), 32'h4);
    wr(a_of(6, 1), 32'h4);
    rd_chk("R9 clear w1", a_of(6, 1), 32'h0);
    chk("R10 irq lingers", {{(2*P-1){1'b0}}, irq}, 1);
    @(negedge clk);
    chk("R10 irq drop", {{(2*P-1){1'b0}}, irq}, '0);

    // R8 both edges, R9 edge beats clear
    wr(a_of(5, 0), 32'h8);
    pins[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R8 both fall", a_of(6, 0), 32'h8);
    pins[3] = 1'b1;
    repeat (2) @(negedge clk);
    addr = a_of(6, 0); wdata = 32'h8; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd_chk("R9 edge wins", a_of(6, 0), 32'h8);
    wr(a_of(6, 0), 32'h8);
    rd_chk("R9 then clears", a_of(6, 0), 32'h0);

    // R11 alternate function
    wr(a_of(7, 1), 32'h0000_00C6);
    chk("R11 altfn", altfn, {{(2*P-64){1'b0}}, 64'h0000_00C6_0000_0000});
    rd_chk("R11 readback", a_of(7, 1), 32'h0000_00C6);

    // R2 unmapped and misaligned
    rd_chk("R2 unmapped", AW'(9*NW*4), 32'h0);
    rd_chk("R2 top", {AW{1'b1}} & ~AW'(3), 32'h0);
    wr(a_of(1, 0) | AW'(2), 32'hFFFF_FFFF);
    rd_chk("R2 misaligned", a_of(1, 0), 32'h0000_00F0);

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      we = 1'b0;
      case ($urandom_range(7, 0))
        0, 1, 2, 3: begin
          int t = $urandom_range(8, 0);
          logic [AW-1:0] a;
          if (t == 8)      a = AW'($urandom_range((1 << AW) - 1, 9*NW*4));
          else if (t == 7) a = a_of(7, $urandom_range(AFW-1, 0));
          else             a = a_of(t, $urandom_range(NW-1, 0));
          if ($urandom_range(9, 0) == 0) a[1:0] = 2'($urandom);
          addr = a; wdata = $urandom; we = 1'b1;
        end
        4, 5: pins[$urandom_range(P-1, 0)] ^= 1'b1;
        default: addr = AW'($urandom);
      endcase
      #1;
      chk("R2 random read", {{(2*P-32){1'b0}}, rdata}, {{(2*P-32){1'b0}}, exp_read(addr)});
      cmp_outputs();
    end
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    cmp_outputs();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule